// File: doc/BRIEF.md
# Serial Display Command and Data Writer

This block writes bytes to a display controller over a write-only, four-wire serial link: an active-low select, a level that tells the display whether the byte is a command or pixel data, a serial clock and a serial data line. A host hands it a request made of a command/data flag and a burst length. The block then pulls the bytes one at a time over a valid/ready byte channel and shifts each one out, most significant bit first.

For every bit the clock falls together with the new data value and rises after one half-period. The data line stays steady while the clock is high. A data burst of any length runs under a single select assertion. A command request always sends exactly one byte. When a transfer ends, all four lines go back high.

The serial clock half-period is set by a divider input: each half lasts `divCfg + 1` system clock cycles. While the block waits for the next byte of a burst, the serial clock holds high and select stays low.

Top module: `disp_serial_writer`

## Requirements
- R1: After reset and whenever `busy` is 0, `csN`, `dcSel`, `sclk` and `sdata` are all 1.
- R2: A request that sends at least one byte pulls `csN` low exactly once. `csN` stays low until the high phase of the last bit ends.
- R3: `dcSel` is 0 for a command request (`reqIsData` = 0) and 1 for a data request (`reqIsData` = 1). It holds that level for as long as `csN` is low, including the eighth rising clock edge of each byte.
- R4: Each byte goes out most significant bit first. The bit value is the level of `sdata` at the rising edge of `sclk`.
- R5: For each bit, `sclk` stays low for exactly `divCfg + 1` cycles, with `sdata` already at the bit value. `sdata` does not change while `sclk` is high and `csN` is low.
- R6: Every high phase of `sclk` between two bits of a transfer lasts at least `divCfg + 1` cycles.
- R7: A data request of length N (N ≥ 1) fetches N bytes over `byteValid`/`byteReady` and sends them back to back, in arrival order, under one select assertion.
- R8: A command request sends exactly one byte, whatever the value of `reqLen`, including 0.
- R9: A data request with `reqLen` = 0 is accepted and completes at once. `busy` never rises and `csN` stays high.
- R10: `reqReady` is 1 only while idle. `busy` is 1 from the acceptance of a request that sends bytes until the lines return to idle.
- R11: While `byteReady` is 1 (waiting for the next byte), `sclk` is 1 and `csN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divCfg | input | DIV_W | Serial clock half-period minus one, in system cycles |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted this cycle when valid (idle) |
| reqIsData | input | 1 | 1 = display data burst, 0 = single command byte |
| reqLen | input | LEN_W | Number of bytes in a data burst |
| byteValid | input | 1 | Next byte offered |
| byteReady | output | 1 | Block takes the offered byte |
| byteData | input | DATA_W | Byte to send |
| busy | output | 1 | Transfer in progress |
| csN | output | 1 | Display select, active low |
| dcSel | output | 1 | Command (0) or data (1) level |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, idles high |

## Verification
The assertions assume `divCfg` is held constant while `busy` is 1, because the low-phase length check compares against its current value. They also assume requests follow the valid/ready rule. The stimulus changes `divCfg` only between transfers, after `busy` has fallen. It holds `reqValid` and `byteValid` until they are taken, and inserts random gaps of zero to two cycles before each byte so that the waiting state is reached.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH
  } sdwState_e;

  typedef struct packed {
    logic acceptReq;
    logic loadByte;
    logic nextBit;
    logic divClear;
    logic divRun;
    logic endXfer;
  } sdwStrobe_t;

endpackage

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
  import sdw_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsData,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             byteValid,
  input  logic             tick,
  output logic             reqReady,
  output logic             byteReady,
  output logic             busy,
  output logic             csN,
  output logic             sclk,
  output sdwStrobe_t       stb
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  sdwState_e state, nextState;
  logic [BIT_W-1:0] bitCnt;
  logic [LEN_W-1:0] remCnt;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid && (!reqIsData || reqLen != '0)) begin
          stb.acceptReq = 1'b1;
          nextState     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (byteValid) begin
          stb.loadByte = 1'b1;
          stb.divClear = 1'b1;
          nextState    = ST_LOW;
        end
      end
      ST_LOW: begin
        stb.divRun = 1'b1;
        if (tick) begin
          stb.divClear = 1'b1;
          nextState    = ST_HIGH;
        end
      end
      ST_HIGH: begin
        stb.divRun = 1'b1;
        if (tick) begin
          stb.divClear = 1'b1;
          if (bitCnt == LAST_BIT) begin
            if (remCnt == LEN_W'(1)) begin
              stb.endXfer = 1'b1;
              nextState   = ST_IDLE;
            end else begin
              nextState = ST_LOAD;
            end
          end else begin
            stb.nextBit = 1'b1;
            nextState   = ST_LOW;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      remCnt <= '0;
    end else begin
      state <= nextState;
      if (stb.acceptReq) remCnt <= reqIsData ? reqLen : LEN_W'(1);
      else if (state == ST_HIGH && tick && bitCnt == LAST_BIT && !stb.endXfer)
        remCnt <= remCnt - LEN_W'(1);
      if (stb.loadByte)     bitCnt <= '0;
      else if (stb.nextBit) bitCnt <= bitCnt + BIT_W'(1);
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign byteReady = (state == ST_LOAD);
  assign csN       = (state == ST_IDLE);
  assign sclk      = (state != ST_LOW);

endmodule

// File: rtl/sdw_datapath.sv
module sdw_datapath
  import sdw_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdwStrobe_t        stb,
  input  logic              reqIsData,
  input  logic [DATA_W-1:0] byteData,
  input  logic [DIV_W-1:0]  divCfg,
  output logic              tick,
  output logic              dcSel,
  output logic              sdata
);
  logic [DATA_W-2:0] restBits;
  logic [DIV_W-1:0]  divCnt;
  logic              sdReg;
  logic              dcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      restBits <= '0;
      sdReg    <= 1'b1;
      dcReg    <= 1'b1;
      divCnt   <= '0;
    end else begin
      if (stb.acceptReq) dcReg <= reqIsData;
      if (stb.endXfer) begin
        dcReg <= 1'b1;
        sdReg <= 1'b1;
      end
      if (stb.loadByte) begin
        restBits <= byteData[DATA_W-2:0];
        sdReg    <= byteData[DATA_W-1];
      end else if (stb.nextBit) begin
        sdReg    <= restBits[DATA_W-2];
        restBits <= {restBits[DATA_W-3:0], 1'b0};
      end
      if (stb.divClear)    divCnt <= '0;
      else if (stb.divRun) divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign tick  = (divCnt == divCfg);
  assign dcSel = dcReg;
  assign sdata = sdReg;

endmodule

// File: rtl/disp_serial_writer.sv
module disp_serial_writer
  import sdw_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divCfg,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsData,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              byteValid,
  output logic              byteReady,
  input  logic [DATA_W-1:0] byteData,
  output logic              busy,
  output logic              csN,
  output logic              dcSel,
  output logic              sclk,
  output logic              sdata
);
  sdwStrobe_t stb;
  logic       tick;

  sdw_ctrl #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsData(reqIsData),
    .reqLen(reqLen), .byteValid(byteValid), .tick(tick),
    .reqReady(reqReady), .byteReady(byteReady), .busy(busy),
    .csN(csN), .sclk(sclk), .stb(stb)
  );

  sdw_datapath #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqIsData(reqIsData),
    .byteData(byteData), .divCfg(divCfg), .tick(tick),
    .dcSel(dcSel), .sdata(sdata)
  );

endmodule

// File: rtl/disp_serial_writer_chk.sv
module disp_serial_writer_chk #(
  parameter int DIV_W = 8,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] divCfg,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqIsData,
  input logic [LEN_W-1:0] reqLen,
  input logic             byteReady,
  input logic             busy,
  input logic             csN,
  input logic             dcSel,
  input logic             sclk,
  input logic             sdata
);
  logic [DIV_W:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lowCnt <= '0;
    else if (!sclk) lowCnt <= lowCnt + 1'b1;
    else            lowCnt <= '0;
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && dcSel && sclk && sdata));

  // R10
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busy);

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqIsData && reqLen == '0) |=> (!busy && csN));

  // R3
  dc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> $stable(dcSel));

  // R5
  sd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk) && !csN && $past(!csN)) |-> $stable(sdata));

  // R5
  low_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclk) && !csN) |-> (lowCnt == ({1'b0, divCfg} + 1'b1)));

  // R11
  wait_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> (sclk && !csN));

endmodule

bind disp_serial_writer disp_serial_writer_chk #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .divCfg(divCfg), .reqValid(reqValid),
  .reqReady(reqReady), .reqIsData(reqIsData), .reqLen(reqLen),
  .byteReady(byteReady), .busy(busy), .csN(csN), .dcSel(dcSel),
  .sclk(sclk), .sdata(sdata)
);

// File: tb/disp_serial_writer_tb.sv
`timescale 1ns/1ps
module disp_serial_writer_tb;
  localparam int DIV_W = 8, LEN_W = 16, DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] divCfg = '0;
  logic reqValid = 1'b0, reqIsData = 1'b0, byteValid = 1'b0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [DATA_W-1:0] byteData = '0;
  logic reqReady, byteReady, busy, csN, dcSel, sclk, sdata;

  always #4 clk = ~clk;

  disp_serial_writer #(.DIV_W(DIV_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .divCfg(divCfg), .reqValid(reqValid),
    .reqReady(reqReady), .reqIsData(reqIsData), .reqLen(reqLen),
    .byteValid(byteValid), .byteReady(byteReady), .byteData(byteData),
    .busy(busy), .csN(csN), .dcSel(dcSel), .sclk(sclk), .sdata(sdata)
  );

  int tests = 0, fails = 0, cycles = 0;
  logic [7:0] expQ[$];
  logic curFlag = 1'b0;
  int curDiv = 0;
  int csFalls = 0, rxCount = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expBytes(input logic isData, input int len);
    if (!isData) return 1;
    return len;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Line monitor, sampled on the falling system clock edge
  logic prevSclk = 1'b1, prevCs = 1'b1, prevSd = 1'b1, seenRise = 1'b0;
  logic [7:0] rxByte = '0;
  int rxBits = 0, lowLen = 0, highLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevCs && !csN) csFalls++;
      if (!prevSclk && sclk && !csN) begin
        // R4 bit captured at rising edge, MSB first; R5 low length
        chk(lowLen == curDiv + 1, "R5 low phase", lowLen, curDiv + 1);
        rxByte = {rxByte[6:0], sdata};
        rxBits++;
        seenRise = 1'b1;
        highLen = 0;
        if (rxBits == 8) begin
          logic [7:0] e;
          e = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
          chk(rxByte === e, "R4 R7 byte", rxByte, e);
          chk(dcSel == curFlag, "R3 dc at 8th edge", dcSel, curFlag);
          rxBits = 0;
          rxCount++;
        end
      end
      if (prevSclk && !sclk && !csN && seenRise)
        chk(highLen >= curDiv + 1, "R6 high phase", highLen, curDiv + 1);
      if (sclk && prevSclk && !csN && !prevCs && sdata != prevSd)
        chk(1'b0, "R5 sdata moved while sclk high", sdata, prevSd);
      if (byteReady && !byteValid)
        chk(sclk && !csN, "R11 wait state lines", {sclk, csN}, 2);
      if (sclk) highLen++;
      if (!sclk) lowLen++; else lowLen = 0;
      if (csN) begin seenRise = 1'b0; rxBits = 0; end
      prevSclk = sclk; prevCs = csN; prevSd = sdata;
    end
  end

  task automatic runReq(input logic isData, input int len, input int div,
                        input int fixedByte);
    int n, fallsBefore, rxBefore;
    n = expBytes(isData, len);
    @(negedge clk);
    divCfg = DIV_W'(div);
    curDiv = div;
    curFlag = isData;
    fallsBefore = csFalls;
    rxBefore = rxCount;
    reqValid = 1'b1; reqIsData = isData; reqLen = LEN_W'(len);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (n == 0) begin
      for (int k = 0; k < 3; k++) begin
        chk(!busy && csN, "R9 zero length stays idle", {busy, csN}, 1);
        @(negedge clk);
      end
    end else begin
      chk(busy && !reqReady, "R10 busy and not ready", {busy, reqReady}, 2);
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        int gap;
        b = (fixedByte >= 0) ? 8'(fixedByte) : 8'($urandom);
        gap = $urandom % 3;
        repeat (gap) @(negedge clk);
        byteData = b; byteValid = 1'b1;
        expQ.push_back(b);
        while (!byteReady) @(negedge clk);
        @(negedge clk);
        byteValid = 1'b0;
      end
      while (busy) @(negedge clk);
    end
    chk(csN && dcSel && sclk && sdata && !busy, "R1 idle after transfer",
        {csN, dcSel, sclk, sdata, busy}, 5'b11110);
    chk(csFalls - fallsBefore == ((n > 0) ? 1 : 0), "R2 one select window",
        csFalls - fallsBefore, (n > 0) ? 1 : 0);
    chk(rxCount - rxBefore == n, isData ? "R7 burst byte count" : "R8 command one byte",
        rxCount - rxBefore, n);
    chk(expQ.size() == 0, "R7 all bytes sent", expQ.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(csN && dcSel && sclk && sdata, "R1 reset lines", {csN, dcSel, sclk, sdata}, 15);
    chk(!busy && reqReady, "R10 reset ready", {busy, reqReady}, 1);
    rstN = 1'b1;
    @(negedge clk);
    // Directed corners
    runReq(1'b1, 1, 0, 8'hA5);
    runReq(1'b1, 3, 2, 8'h00);
    runReq(1'b1, 2, 1, 8'hFF);
    runReq(1'b0, 7, 3, 8'h3C);   // R8 command ignores length
    runReq(1'b0, 0, 1, -1);      // R8 command with zero length
    runReq(1'b1, 0, 2, -1);      // R9
    runReq(1'b1, 0, 0, -1);      // R9
    // Random mix
    for (int t = 0; t < 30; t++) begin
      logic isData;
      int len;
      isData = ($urandom % 4) != 0;
      len = $urandom % 7;
      runReq(isData, len, $urandom % 4, -1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule